// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a watchdog timer that counts enable pulses from a slow, dedicated watchdog clock. The pulses pass through a prescaler, and a 4-bit period code picks the prescaler tap that ends the time-out. On expiry the block either asks for a system reset or raises an interrupt request, depending on a mode bit, so it can also act as a wake-up source. Software restarts the count with a kick strobe.

Configuration changes are guarded. A static safety-level input picks one of two policies. At the relaxed level the timer starts disabled, software may turn it on freely, and turning it off needs an unlock. At the strict level the timer always runs, and any change to the control register needs an unlock. An unlock opens a short write window. Software opens it by writing a signature byte to a separate key register.

Top module: `wdg_guard`

## Requirements
- R1: After reset, level 1 (`safety_lvl`=0) reads the control register as 8'h00. Level 2 (`safety_lvl`=1) reads it as 8'h10. `irq_req` and `sys_rst_req` are low. The control layout is: period code in bits [3:0], enable in bit 4, mode in bit 5 (1 selects interrupt, 0 selects reset), pending interrupt in bit 6, and 0 in bit 7.
- R2: At level 1, a control write (`wr_sel`=0) is accepted with no unlock when it does not clear a set enable bit. This covers enabling the timer and changing the period of a running timer. While the enable bit reads 0, the timer never requests a reset or an interrupt.
- R3: At level 1, a write that clears a set enable bit is accepted only while the window is open, and it updates enable, mode and period together. With the window closed, the whole write is dropped and the register keeps its contents.
- R4: At level 2 the enable bit always reads 1 and the timer always counts. The enable value carried by any write is ignored.
- R5: At level 2, a control write is accepted (period and mode) only while the window is open. Otherwise it is dropped and the register keeps its contents.
- R6: Writing 8'hD8 to the key register (`wr_sel`=1) opens the window for control writes on the next `WIN_CYCLES` (default 4) clock edges. Any other key value has no effect. The first control write made while the window is open closes it.
- R7: With the timer running, a time-out takes 2^(`BASE_LOG2`+code) `wdt_tick` pulses counted from the last kick, expiry or enable. Codes at or above `NUM_CODES`-1 (default 9) all behave as code `NUM_CODES`-1.
- R8: On expiry in reset mode, `sys_rst_req` is high for exactly one cycle, and the count restarts from zero.
- R9: On expiry in interrupt mode, `irq_req` (and bit 6) goes high and stays high until a kick. Counting continues, and no reset is requested.
- R10: A kick clears the count and the pending interrupt, and it takes priority over an expiry on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| safety_lvl | input | 1 | Static policy select: 0 = level 1, 1 = level 2 |
| wdt_tick | input | 1 | One-cycle enable pulse from the watchdog oscillator |
| kick | input | 1 | Restart strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = key register |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register read view |
| irq_req | output | 1 | Time-out interrupt request (level) |
| sys_rst_req | output | 1 | Time-out system reset request (one-cycle pulse) |

## Verification
The properties assume that `safety_lvl` holds still between resets and changes only while `rst_n` is low. They also assume that `wr_en` targets exactly one register per cycle through `wr_sel`. The stimulus follows both rules: it changes the level only inside a reset, and it drives every input one time unit after the rising edge. Ticks, kicks and writes are randomised, including signature and near-signature key values. The directed sequences place control writes on the last open edge of the window and on the first closed edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned PER_W      = 4;
   localparam int unsigned NUM_SEL    = 1 << PER_W;
   localparam logic [REG_W-1:0] UNLOCK_SIG = 8'hD8;
   localparam int unsigned EN_BIT     = 4;
   localparam int unsigned MODE_BIT   = 5;
   localparam int unsigned PEND_BIT   = 6;

   typedef struct packed {
      logic             irq_mode;
      logic             run;
      logic [PER_W-1:0] per;
   } wdg_cfg_t;
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
   import wdg_pkg::*;
#(
   parameter int unsigned WIN_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [REG_W-1:0] key_data,
   input  logic             cfg_wr,
   output logic             win_open
);
   localparam int unsigned WC_W = $clog2(WIN_CYCLES + 1);

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("wdg_unlock: WIN_CYCLES must be at least 1");
   end

   logic [WC_W-1:0] left_q;
   logic            sig_hit;

   assign sig_hit  = key_wr && (key_data == UNLOCK_SIG);
   assign win_open = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (sig_hit) begin
         left_q <= WC_W'(WIN_CYCLES);
      end else if (cfg_wr && win_open) begin
         left_q <= '0;
      end else if (win_open) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       safety_lvl,
   input  logic       cfg_wr,
   input  logic [5:0] cfg_data,
   input  logic       win_open,
   output wdg_cfg_t   cfg
);
   logic             en_q;
   logic             mode_q;
   logic [PER_W-1:0] per_q;
   logic             accept;
   logic             turn_off;

   assign turn_off = en_q && !cfg_data[EN_BIT];

   always_comb begin
      accept = 1'b0;
      if (cfg_wr) begin
         if (safety_lvl) begin
            accept = win_open;
         end else begin
            accept = win_open || !turn_off;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         per_q  <= '0;
      end else if (accept) begin
         per_q  <= cfg_data[PER_W-1:0];
         mode_q <= cfg_data[MODE_BIT];
         if (!safety_lvl) begin
            en_q <= cfg_data[EN_BIT];
         end
      end
   end

   assign cfg.run      = safety_lvl || en_q;
   assign cfg.irq_mode = mode_q;
   assign cfg.per      = per_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 11,
   parameter int unsigned NUM_CODES = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             kick,
   input  logic             run,
   input  logic             irq_mode,
   input  logic [PER_W-1:0] per,
   output logic             irq_pend,
   output logic             rst_pulse
);
   localparam int unsigned CNT_W = BASE_LOG2 + NUM_CODES - 1;

   if (NUM_CODES < 1 || NUM_CODES > NUM_SEL) begin : g_bad_codes
      $error("wdg_timer: NUM_CODES out of range");
   end
   if (BASE_LOG2 < 1 || CNT_W > 40) begin : g_bad_base
      $error("wdg_timer: BASE_LOG2 out of range");
   end

   logic [CNT_W-1:0] term_tab [NUM_SEL];
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
      localparam int unsigned CODE = (g < NUM_CODES) ? g : NUM_CODES - 1;
      localparam int unsigned EXP  = BASE_LOG2 + CODE;
      assign term_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
   end

   assign hit = (cnt_q >= term_tab[per]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         irq_pend  <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= 1'b0;
         if (kick) begin
            cnt_q    <= '0;
            irq_pend <= 1'b0;
         end else if (!run) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (hit) begin
               cnt_q <= '0;
               if (irq_mode) begin
                  irq_pend <= 1'b1;
               end else begin
                  rst_pulse <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
   import wdg_pkg::*;
#(
   parameter int unsigned BASE_LOG2  = 11,
   parameter int unsigned NUM_CODES  = 10,
   parameter int unsigned WIN_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       safety_lvl,
   input  logic       wdt_tick,
   input  logic       kick,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] ctrl_rd,
   output logic       irq_req,
   output logic       sys_rst_req
);
   logic     cfg_wr;
   logic     key_wr;
   logic     win_open;
   logic     irq_pend;
   wdg_cfg_t cfg;

   assign cfg_wr = wr_en && !wr_sel;
   assign key_wr = wr_en && wr_sel;

   wdg_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (wr_data),
      .cfg_wr   (cfg_wr),
      .win_open (win_open)
   );

   wdg_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .safety_lvl (safety_lvl),
      .cfg_wr     (cfg_wr),
      .cfg_data   (wr_data[5:0]),
      .win_open   (win_open),
      .cfg        (cfg)
   );

   wdg_timer #(.BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (wdt_tick),
      .kick      (kick),
      .run       (cfg.run),
      .irq_mode  (cfg.irq_mode),
      .per       (cfg.per),
      .irq_pend  (irq_pend),
      .rst_pulse (sys_rst_req)
   );

   assign ctrl_rd = {1'b0, irq_pend, cfg.irq_mode, cfg.run, cfg.per};
   assign irq_req = irq_pend;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       safety_lvl,
   input logic       kick,
   input logic       wr_en,
   input logic       wr_sel,
   input logic [7:0] wr_data,
   input logic [7:0] ctrl_rd,
   input logic       irq_req,
   input logic       sys_rst_req,
   input logic       win_open
);
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req); // R8
   AST_LVL2_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      safety_lvl |-> ctrl_rd[4]); // R4
   AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !irq_req); // R10
   AST_LVL2_CLOSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (safety_lvl && wr_en && !wr_sel && !win_open) |=> $stable(ctrl_rd[5:0])); // R5
   AST_OFF_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (!safety_lvl && !ctrl_rd[4]) |=> !sys_rst_req); // R2
   AST_OFF_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!safety_lvl && ctrl_rd[4] && wr_en && !wr_sel && !wr_data[4] && !win_open)
      |=> ctrl_rd[4]); // R3
   AST_IRQ_MODE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd[5] |=> !sys_rst_req); // R9
endmodule

bind wdg_guard wdg_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .safety_lvl  (safety_lvl),
   .kick        (kick),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .ctrl_rd     (ctrl_rd),
   .irq_req     (irq_req),
   .sys_rst_req (sys_rst_req),
   .win_open    (win_open)
);

// File: tb/tb_wdg_guard.sv
`timescale 1ns/1ps
module tb_wdg_guard;
   localparam int BASE = 3;
   localparam int NCODES = 10;
   localparam int WIN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lvl = 1'b0;
   logic       tick = 1'b1;
   logic       kick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] ctrl_rd;
   logic       irq_req;
   logic       sys_rst_req;

   int checks = 0;
   int fails = 0;
   bit started = 0;

   // reference model state
   int m_win, m_en, m_per, m_mode, m_pend, m_cnt, m_rst;
   int o_en, o_per, o_mode, o_open, o_code;

   always #4 clk = ~clk;

   wdg_guard #(.BASE_LOG2(BASE), .NUM_CODES(NCODES), .WIN_CYCLES(WIN)) dut (
      .clk(clk), .rst_n(rst_n), .safety_lvl(lvl), .wdt_tick(tick), .kick(kick),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ctrl_rd(ctrl_rd), .irq_req(irq_req), .sys_rst_req(sys_rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_win = 0; m_en = 0; m_per = 0; m_mode = 0; m_pend = 0; m_cnt = 0; m_rst = 0;
      end else begin
         o_en = lvl ? 1 : m_en; o_per = m_per; o_mode = m_mode; o_open = (m_win > 0);
         o_code = (o_per < NCODES) ? o_per : NCODES - 1;
         m_rst = 0;
         if (kick) begin
            m_cnt = 0; m_pend = 0;
         end else if (o_en == 0) begin
            m_cnt = 0;
         end else if (tick) begin
            if (m_cnt >= (1 << (BASE + o_code)) - 1) begin
               m_cnt = 0;
               if (o_mode != 0) m_pend = 1; else m_rst = 1;
            end else m_cnt++;
         end
         if (wr_en && !wr_sel) begin
            if (lvl) begin
               if (o_open) begin m_per = wr_data[3:0]; m_mode = wr_data[5]; end
            end else if (o_open || !(m_en == 1 && wr_data[4] == 1'b0)) begin
               m_en = wr_data[4]; m_per = wr_data[3:0]; m_mode = wr_data[5];
            end
         end
         if (wr_en && wr_sel && wr_data == 8'hD8) m_win = WIN;
         else if (wr_en && !wr_sel && o_open) m_win = 0;
         else if (o_open) m_win--;
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (started && rst_n) begin
         chk("R3 ctrl_rd model", ctrl_rd,
             {1'b0, m_pend[0], m_mode[0], (lvl | m_en[0]), m_per[3:0]});
         chk("R9 irq_req model", irq_req, m_pend);
         chk("R8 sys_rst_req model", sys_rst_req, m_rst);
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      cyc();
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic do_kick();
      kick = 1'b1;
      cyc();
      kick = 1'b0;
   endtask

   task automatic do_reset(input logic level);
      rst_n = 1'b0;
      cyc();
      lvl = level;
      cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   // cycles until the given output goes high
   task automatic measure(input bit want_irq, output int n);
      n = 0;
      for (int i = 0; i < 20000; i++) begin
         cyc();
         n++;
         if (want_irq ? irq_req : sys_rst_req) break;
      end
   endtask

   task automatic random_phase(input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         int r;
         r = $urandom_range(0, 99);
         tick = ($urandom_range(0, 3) != 0);
         kick = (r < 3);
         wr_en = (r >= 90);
         wr_sel = $urandom_range(0, 1);
         case ($urandom_range(0, 3))
            0: wr_data = 8'hD8;
            1: wr_data = 8'hD9;
            default: wr_data = 8'($urandom_range(0, 255)) & 8'h3F;
         endcase
         cyc();
      end
      tick = 1'b1; kick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
   endtask

   initial begin
      int n;
      int seen;
      do_reset(1'b0);
      chk("R1 level1 reset ctrl", ctrl_rd, 8'h00);
      chk("R1 reset irq", irq_req, 0);
      chk("R1 reset sysrst", sys_rst_req, 0);

      wr(1'b0, 8'h10);
      chk("R2 free enable", ctrl_rd, 8'h10);
      measure(1'b0, n);
      chk("R7 code0 timeout", n, 8);
      cyc();
      chk("R8 pulse one cycle", sys_rst_req, 0);

      wr(1'b0, 8'h12);
      chk("R2 free period change", ctrl_rd, 8'h12);
      do_kick();
      measure(1'b0, n);
      chk("R7 code2 timeout", n, 32);

      wr(1'b0, 8'h1F);
      do_kick();
      measure(1'b0, n);
      chk("R7 reserved code timeout", n, 4096);

      wr(1'b0, 8'h00);
      chk("R3 closed disable dropped", ctrl_rd, 8'h1F);
      wr(1'b1, 8'hD7);
      wr(1'b0, 8'h00);
      chk("R6 wrong signature", ctrl_rd, 8'h1F);
      wr(1'b1, 8'hD8);
      repeat (WIN) cyc();
      wr(1'b0, 8'h00);
      chk("R6 window expired", ctrl_rd, 8'h1F);
      wr(1'b1, 8'hD8);
      repeat (WIN - 1) cyc();
      wr(1'b0, 8'h03);
      chk("R3 disable inside window", ctrl_rd, 8'h03);
      seen = 0;
      for (int i = 0; i < 100; i++) begin
         cyc();
         if (sys_rst_req || irq_req) seen++;
      end
      chk("R2 disabled stays quiet", seen, 0);

      wr(1'b0, 8'h10);
      wr(1'b1, 8'hD8);
      wr(1'b0, 8'h11);
      wr(1'b0, 8'h00);
      chk("R6 window consumed", ctrl_rd, 8'h11);

      wr(1'b0, 8'h30);
      do_kick();
      measure(1'b1, n);
      chk("R9 irq timeout", n, 8);
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         cyc();
         if (sys_rst_req) seen++;
      end
      chk("R9 irq held", irq_req, 1);
      chk("R9 no reset in irq mode", seen, 0);
      do_kick();
      chk("R10 kick clears irq", irq_req, 0);
      seen = 0;
      for (int i = 0; i < 100; i++) begin
         if (i % 5 == 0) kick = 1'b1;
         cyc();
         kick = 1'b0;
         if (irq_req) seen++;
      end
      chk("R10 regular kicks prevent expiry", seen, 0);

      random_phase(3000);

      do_reset(1'b1);
      chk("R1 R4 level2 reset ctrl", ctrl_rd, 8'h10);
      wr(1'b0, 8'h02);
      chk("R5 closed write dropped", ctrl_rd, 8'h10);
      wr(1'b1, 8'hD8);
      wr(1'b0, 8'h02);
      chk("R4 R5 period in window enable ignored", ctrl_rd, 8'h12);
      do_kick();
      measure(1'b0, n);
      chk("R7 R8 level2 timeout", n, 32);

      random_phase(3000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule